// File: doc/BRIEF.md
# Queued software interrupt controller

This block owns the interrupt-address register and the interrupt queueing flag of a small 16-bit processor, and it runs the interrupt entry and return sequences for it. The instruction decoder hands it one operation at a time through a strobe, a kind code and a 16-bit operand. The operations are:

- raise a software interrupt carrying the operand as its message;
- read the interrupt address;
- write the interrupt address;
- return from an interrupt;
- switch queueing on or off.

The block answers with a busy flag, a done pulse and read data. It drives the stack push and pop strobes and the write strobes of the PC and the A register.

Entering an interrupt saves PC and then A on the stack. It then jumps to the interrupt address with the message in A, and it turns queueing on. While queueing is on, new interrupts are parked in a message FIFO instead of being taken. Hardware sources write their messages into the same FIFO through a second request port. Once queueing is off again, the oldest parked message is taken at the next instruction boundary that the core signals.

Top module: `swint_ctrl`

## Requirements
- R1: After reset the interrupt address reads 0, queueing is off, the fault flag is low, op_busy is low, and the FIFO is empty, so an instruction boundary delivers nothing.
- R2: An operation is accepted on a clock edge where the block is idle and op_valid is high with a known kind: 1 = software interrupt, 2 = read address, 3 = write address, 4 = return, 5 = queue control. A write (kind 3) loads the interrupt address from op_arg. A read (kind 2) shows the address on op_rdata with op_done in the first cycle after acceptance. Both kinds take 1 cycle.
- R3: A software interrupt taken with queueing off and a nonzero interrupt address runs 4 cycles after acceptance. Cycle 1 pushes pc_cur and cycle 2 pushes a_cur. Cycle 3 writes PC with the interrupt address and A with the message, and queueing reads on from cycle 4. Cycle 4 pulses op_done.
- R4: A software interrupt with queueing off and an interrupt address of 0 is discarded. There is no push and no PC or A write, queueing is unchanged, and op_done still comes in cycle 4.
- R5: Return (kind 4) takes 3 cycles. Queueing reads off from cycle 1. Cycle 1 pops and writes A with stk_rdata, cycle 2 pops and writes PC with stk_rdata, and cycle 3 pulses op_done.
- R6: Queue control (kind 5) takes 2 cycles. A nonzero op_arg turns queueing on and a zero op_arg turns it off, visible from cycle 2, which also pulses op_done.
- R7: A software interrupt accepted while queueing is on stores its message in the FIFO. It causes no stack or register activity and still completes in 4 cycles.
- R8: Every cycle with hw_req high stores hw_msg in the FIFO, busy or not. When that coincides with a software message being stored, the software message is placed first.
- R9: When the block is idle, no operation is accepted, queueing is off, insn_bnd is high and the FIFO holds a message, the oldest message is removed. It is then taken with the R3 sequence, or discarded as in R4, without op_done.
- R10: The FIFO holds 2**DEPTH_LOG2 messages (256 by default). A message arriving when no slot is free is dropped and ovf_fault rises and stays high until reset.
- R11: op_valid is ignored while op_busy is high, and kind codes 0, 6 and 7 are ignored. Neither starts any activity.
- R12: op_busy is high from the cycle after acceptance, or after delivery, through the final cycle of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe from decode |
| op_kind | input | 3 | Operation kind code |
| op_arg | input | 16 | Operation operand |
| op_busy | output | 1 | A sequence is running |
| op_done | output | 1 | Final cycle of an accepted operation |
| op_rdata | output | 16 | Interrupt address captured by a read |
| hw_req | input | 1 | Hardware message push strobe |
| hw_msg | input | 16 | Hardware message |
| insn_bnd | input | 1 | Core is at an instruction boundary |
| pc_cur | input | 16 | Address of the next instruction |
| a_cur | input | 16 | Current A register value |
| stk_push | output | 1 | Push stk_wdata |
| stk_wdata | output | 16 | Data to push |
| stk_pop | output | 1 | Pop the stack top |
| stk_rdata | input | 16 | Stack top, valid in the pop cycle |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 16 | New PC |
| a_we | output | 1 | A write strobe |
| a_wdata | output | 16 | New A |
| queueing | output | 1 | Queueing flag |
| ovf_fault | output | 1 | Sticky FIFO overflow flag |

## Verification
The assertions assume three things about the inputs:

- stk_rdata holds the value being popped in the same cycle as stk_pop;
- pc_cur and a_cur are stable while they are being pushed;
- op_kind and op_arg are valid whenever op_valid is high.

The bench models a real stack that returns what was pushed, and holds pc_cur and a_cur constant through each sequence. It raises op_valid for exactly one cycle per operation, and it pulses insn_bnd only while the block is idle. It brings hardware requests in alongside a software interrupt to test FIFO order. It then fills the FIFO to overflow and drains it completely, which shows that the dropped message never comes out.

// File: rtl/swint_pkg.sv
package swint_pkg;

  typedef enum logic [2:0] {
    OPK_NONE = 3'd0,
    OPK_SWI  = 3'd1,
    OPK_IARD = 3'd2,
    OPK_IAWR = 3'd3,
    OPK_RETI = 3'd4,
    OPK_QCTL = 3'd5
  } opk_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_E_PC,
    ST_E_A,
    ST_E_LD,
    ST_E_FIN,
    ST_R_A,
    ST_R_PC,
    ST_R_FIN,
    ST_Q_SET,
    ST_Q_FIN,
    ST_X_FIN
  } seq_st_e;

endpackage

// File: rtl/swint_iareg.sv
module swint_iareg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] ia,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] ia_q, ia_n;
  logic [DW-1:0] rd_q, rd_n;

  always_comb begin
    ia_n = ia_q;
    rd_n = rd_q;
    if (wr_en) ia_n = wr_data;
    if (rd_en) rd_n = ia_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ia_q <= '0;
      rd_q <= '0;
    end else begin
      if (wr_en) ia_q <= ia_n;
      if (rd_en) rd_q <= rd_n;
    end
  end

  assign ia    = ia_q;
  assign rdata = rd_q;

  // R2
  ia_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (ia_q == $past(ia_q)));

endmodule

// File: rtl/swint_fifo.sv
module swint_fifo #(
  parameter int DW         = 16,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push0,
  input  logic [DW-1:0] data0,
  input  logic          push1,
  input  logic [DW-1:0] data1,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          fault
);

  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int CW    = DEPTH_LOG2 + 1;
  localparam int AW    = DEPTH_LOG2;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n, wp_alt;
  logic [CW-1:0] cnt_q, cnt_n, avail;
  logic          fault_q, fault_n;
  logic          pop_ok, acc0, acc1, drop;

  always_comb begin
    pop_ok  = pop && (cnt_q != '0);
    avail   = cnt_q - CW'(pop_ok);
    acc0    = push0 && (avail < CW'(DEPTH));
    acc1    = push1 && ((avail + CW'(acc0)) < CW'(DEPTH));
    drop    = (push0 && !acc0) || (push1 && !acc1);
    wp_alt  = wp_q + AW'(acc0);
    wp_n    = wp_q + AW'(acc0) + AW'(acc1);
    rp_n    = rp_q + AW'(pop_ok);
    cnt_n   = avail + CW'(acc0) + CW'(acc1);
    fault_n = fault_q | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      wp_q    <= wp_n;
      rp_q    <= rp_n;
      cnt_q   <= cnt_n;
      fault_q <= fault_n;
    end
  end

  always_ff @(posedge clk) begin
    if (acc0) mem[wp_q]   <= data0;
    if (acc1) mem[wp_alt] <= data1;
  end

  assign head  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign fault = fault_q;

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && !pop && push1) |=> fault_q);

endmodule

// File: rtl/swint_seq.sv
module swint_seq
  import swint_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_kind,
  input  logic [DW-1:0] op_arg,
  input  logic [DW-1:0] ia,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_head,
  input  logic          insn_bnd,
  input  logic [DW-1:0] pc_cur,
  input  logic [DW-1:0] a_cur,
  input  logic [DW-1:0] stk_rdata,
  output logic          fifo_pop,
  output logic          enq_valid,
  output logic          ia_wr,
  output logic          ia_rd,
  output logic          stk_push,
  output logic [DW-1:0] stk_wdata,
  output logic          stk_pop,
  output logic          pc_we,
  output logic [DW-1:0] pc_wdata,
  output logic          a_we,
  output logic [DW-1:0] a_wdata,
  output logic          op_busy,
  output logic          op_done,
  output logic          queueing
);

  seq_st_e       st_q, st_n;
  logic          take_q, take_n;
  logic          fromop_q, fromop_n;
  logic          argnz_q, argnz_n;
  logic          qf_q, qf_n;
  logic [DW-1:0] msg_q, msg_n;
  logic          ctx_en;
  logic          kind_ok, accept, deliver;

  always_comb begin
    kind_ok = (op_kind == OPK_SWI)  || (op_kind == OPK_IARD) ||
              (op_kind == OPK_IAWR) || (op_kind == OPK_RETI) ||
              (op_kind == OPK_QCTL);
    accept  = (st_q == ST_IDLE) && op_valid && kind_ok;
    deliver = (st_q == ST_IDLE) && !accept && insn_bnd && !qf_q && !fifo_empty;
  end

  always_comb begin
    st_n      = st_q;
    take_n    = take_q;
    fromop_n  = fromop_q;
    argnz_n   = argnz_q;
    qf_n      = qf_q;
    msg_n     = msg_q;
    ctx_en    = 1'b0;
    fifo_pop  = 1'b0;
    enq_valid = 1'b0;
    ia_wr     = 1'b0;
    ia_rd     = 1'b0;
    stk_push  = 1'b0;
    stk_wdata = '0;
    stk_pop   = 1'b0;
    pc_we     = 1'b0;
    pc_wdata  = '0;
    a_we      = 1'b0;
    a_wdata   = '0;
    op_done   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          ctx_en   = 1'b1;
          fromop_n = 1'b1;
          unique case (op_kind)
            OPK_SWI: begin
              enq_valid = qf_q;
              take_n    = !qf_q && (ia != '0);
              msg_n     = op_arg;
              st_n      = ST_E_PC;
            end
            OPK_IARD: begin
              ia_rd = 1'b1;
              st_n  = ST_X_FIN;
            end
            OPK_IAWR: begin
              ia_wr = 1'b1;
              st_n  = ST_X_FIN;
            end
            OPK_RETI: begin
              qf_n = 1'b0;
              st_n = ST_R_A;
            end
            default: begin
              argnz_n = (op_arg != '0);
              st_n    = ST_Q_SET;
            end
          endcase
        end else if (deliver) begin
          ctx_en   = 1'b1;
          fifo_pop = 1'b1;
          fromop_n = 1'b0;
          take_n   = (ia != '0);
          msg_n    = fifo_head;
          st_n     = ST_E_PC;
        end
      end
      ST_E_PC: begin
        stk_push  = take_q;
        stk_wdata = pc_cur;
        st_n      = ST_E_A;
      end
      ST_E_A: begin
        stk_push  = take_q;
        stk_wdata = a_cur;
        st_n      = ST_E_LD;
      end
      ST_E_LD: begin
        pc_we    = take_q;
        pc_wdata = ia;
        a_we     = take_q;
        a_wdata  = msg_q;
        if (take_q) qf_n = 1'b1;
        st_n     = ST_E_FIN;
      end
      ST_E_FIN: begin
        op_done = fromop_q;
        st_n    = ST_IDLE;
      end
      ST_R_A: begin
        stk_pop = 1'b1;
        a_we    = 1'b1;
        a_wdata = stk_rdata;
        st_n    = ST_R_PC;
      end
      ST_R_PC: begin
        stk_pop  = 1'b1;
        pc_we    = 1'b1;
        pc_wdata = stk_rdata;
        st_n     = ST_R_FIN;
      end
      ST_Q_SET: begin
        qf_n = argnz_q;
        st_n = ST_Q_FIN;
      end
      ST_R_FIN, ST_Q_FIN, ST_X_FIN: begin
        op_done = 1'b1;
        st_n    = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      take_q   <= 1'b0;
      fromop_q <= 1'b0;
      argnz_q  <= 1'b0;
      qf_q     <= 1'b0;
      msg_q    <= '0;
    end else begin
      st_q <= st_n;
      qf_q <= qf_n;
      if (ctx_en) begin
        take_q   <= take_n;
        fromop_q <= fromop_n;
        argnz_q  <= argnz_n;
        msg_q    <= msg_n;
      end
    end
  end

  assign op_busy  = (st_q != ST_IDLE);
  assign queueing = qf_q;

  // R5
  reti_first_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_kind == OPK_RETI) |=> (stk_pop && a_we && !queueing));

  // R3
  push_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_push && !$past(stk_push)) |=> stk_push);

  // R3
  entry_qon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && a_we) |=> queueing);

  // R4
  zero_ia_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_kind == OPK_SWI && !qf_q && ia == '0)
      |=> !stk_push ##1 !stk_push ##1 (!pc_we && !a_we));

  // R7
  queued_swi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_kind == OPK_SWI && qf_q) |-> enq_valid);

  // R12
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> op_busy);

  // R11
  busy_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |-> !fifo_pop);

  // R3
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_push && stk_pop));

endmodule

// File: rtl/swint_ctrl.sv
module swint_ctrl
  import swint_pkg::*;
#(
  parameter int DW         = 16,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_kind,
  input  logic [DW-1:0] op_arg,
  output logic          op_busy,
  output logic          op_done,
  output logic [DW-1:0] op_rdata,
  input  logic          hw_req,
  input  logic [DW-1:0] hw_msg,
  input  logic          insn_bnd,
  input  logic [DW-1:0] pc_cur,
  input  logic [DW-1:0] a_cur,
  output logic          stk_push,
  output logic [DW-1:0] stk_wdata,
  output logic          stk_pop,
  input  logic [DW-1:0] stk_rdata,
  output logic          pc_we,
  output logic [DW-1:0] pc_wdata,
  output logic          a_we,
  output logic [DW-1:0] a_wdata,
  output logic          queueing,
  output logic          ovf_fault
);

  logic [1:0]    rsync_q;
  logic          rst_s_n;
  logic [DW-1:0] ia;
  logic          ia_wr, ia_rd;
  logic          fifo_empty, fifo_pop, enq_valid;
  logic [DW-1:0] fifo_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  swint_iareg #(.DW(DW)) u_iareg (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (ia_wr),
    .wr_data (op_arg),
    .rd_en   (ia_rd),
    .ia      (ia),
    .rdata   (op_rdata)
  );

  swint_fifo #(.DW(DW), .DEPTH_LOG2(DEPTH_LOG2)) u_fifo (
    .clk   (clk),
    .rst_n (rst_s_n),
    .push0 (enq_valid),
    .data0 (op_arg),
    .push1 (hw_req),
    .data1 (hw_msg),
    .pop   (fifo_pop),
    .head  (fifo_head),
    .empty (fifo_empty),
    .fault (ovf_fault)
  );

  swint_seq #(.DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_arg     (op_arg),
    .ia         (ia),
    .fifo_empty (fifo_empty),
    .fifo_head  (fifo_head),
    .insn_bnd   (insn_bnd),
    .pc_cur     (pc_cur),
    .a_cur      (a_cur),
    .stk_rdata  (stk_rdata),
    .fifo_pop   (fifo_pop),
    .enq_valid  (enq_valid),
    .ia_wr      (ia_wr),
    .ia_rd      (ia_rd),
    .stk_push   (stk_push),
    .stk_wdata  (stk_wdata),
    .stk_pop    (stk_pop),
    .pc_we      (pc_we),
    .pc_wdata   (pc_wdata),
    .a_we       (a_we),
    .a_wdata    (a_wdata),
    .op_busy    (op_busy),
    .op_done    (op_done),
    .queueing   (queueing)
  );

endmodule

// File: tb/test_swint_ctrl.sv
module test_swint_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;

  localparam int EV_PUSH = 1;
  localparam int EV_POP  = 2;
  localparam int EV_PCW  = 3;
  localparam int EV_AW   = 4;
  localparam int EV_DONE = 5;

  typedef struct {
    int          k;
    bit          c;
    logic [15:0] d;
    string       r;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, hw_req, insn_bnd;
  logic [2:0]  op_kind;
  logic [15:0] op_arg, hw_msg, pc_cur, a_cur, stk_rdata;
  logic        op_busy, op_done, stk_push, stk_pop, pc_we, a_we, queueing, ovf_fault;
  logic [15:0] op_rdata, stk_wdata, pc_wdata, a_wdata;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  mon_en = 1'b0;
  bit  ended  = 1'b0;
  ev_t expq[$];

  logic [15:0] stk_mem [1024];
  int          sp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swint_ctrl i_swint_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_arg(op_arg),
    .op_busy(op_busy), .op_done(op_done), .op_rdata(op_rdata), .hw_req(hw_req),
    .hw_msg(hw_msg), .insn_bnd(insn_bnd), .pc_cur(pc_cur), .a_cur(a_cur),
    .stk_push(stk_push), .stk_wdata(stk_wdata), .stk_pop(stk_pop), .stk_rdata(stk_rdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .a_we(a_we), .a_wdata(a_wdata),
    .queueing(queueing), .ovf_fault(ovf_fault)
  );

  always_comb stk_rdata = (sp > 0) ? stk_mem[sp-1] : 16'hDEAD;

  always @(posedge clk) begin
    if (stk_push && sp < 1024) begin
      stk_mem[sp] <= stk_wdata;
      sp <= sp + 1;
    end else if (stk_pop && sp > 0) begin
      sp <= sp - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FIFO-CTRL FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic void expect_ev(input int k, input bit c, input logic [15:0] d, input string r);
    ev_t e;
    e.k = k; e.c = c; e.d = d; e.r = r;
    expq.push_back(e);
  endfunction

  task automatic see(input int k, input logic [15:0] d);
    ev_t e;
    if (expq.size() == 0) begin
      chk(1'b0, "unexpected output event", k * 65536 + int'(d), 0);
    end else begin
      e = expq.pop_front();
      chk(e.k == k && (!e.c || e.d == d), e.r, k * 65536 + int'(d), e.k * 65536 + int'(e.d));
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (stk_push) see(EV_PUSH, stk_wdata);
      if (stk_pop)  see(EV_POP, 16'h0);
      if (pc_we)    see(EV_PCW, pc_wdata);
      if (a_we)     see(EV_AW, a_wdata);
      if (op_done)  see(EV_DONE, op_rdata);
    end
  end

  function automatic void expect_entry(input logic [15:0] pc, input logic [15:0] a,
                                       input logic [15:0] iav, input logic [15:0] msg,
                                       input bit with_done, input string r);
    expect_ev(EV_PUSH, 1'b1, pc, r);
    expect_ev(EV_PUSH, 1'b1, a, r);
    expect_ev(EV_PCW, 1'b1, iav, r);
    expect_ev(EV_AW, 1'b1, msg, r);
    if (with_done) expect_ev(EV_DONE, 1'b0, 16'h0, r);
  endfunction

  task automatic do_op(input logic [2:0] k, input logic [15:0] arg, input int lat,
                       input string req, input bit hw, input logic [15:0] hwm);
    int n;
    while (op_busy) @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_arg = arg; hw_req = hw; hw_msg = hwm;
    @(negedge clk);
    op_valid = 1'b0; hw_req = 1'b0;
    n = 0;
    while (op_busy && n < 50) begin
      n++;
      @(negedge clk);
    end
    chk(n == lat, req, n, lat);
  endtask

  task automatic deliver(input int lat, input string req);
    int n;
    while (op_busy) @(negedge clk);
    insn_bnd = 1'b1;
    @(negedge clk);
    insn_bnd = 1'b0;
    n = 0;
    while (op_busy && n < 50) begin
      n++;
      @(negedge clk);
    end
    chk(n == lat, req, n, lat);
  endtask

  task automatic do_reset();
    mon_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FIFO-CTRL FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    op_valid = 1'b0; op_kind = 3'd0; op_arg = 16'h0; hw_req = 1'b0; hw_msg = 16'h0;
    insn_bnd = 1'b0; pc_cur = 16'h0; a_cur = 16'h0;
    do_reset();

    // R1: reset state
    chk(op_busy == 1'b0, "R1 busy", int'(op_busy), 0);
    chk(queueing == 1'b0, "R1 queueing", int'(queueing), 0);
    chk(ovf_fault == 1'b0, "R1 fault", int'(ovf_fault), 0);
    expect_ev(EV_DONE, 1'b1, 16'h0000, "R1 address reads 0");
    do_op(3'd2, 16'h0, 1, "R2 read latency", 1'b0, 16'h0);
    deliver(0, "R1 empty FIFO delivers nothing");

    // R4: zero address discards
    expect_ev(EV_DONE, 1'b0, 16'h0, "R4 done only");
    do_op(3'd1, 16'h0011, 4, "R4 latency", 1'b0, 16'h0);
    chk(queueing == 1'b0, "R4 queueing unchanged", int'(queueing), 0);

    // R2: write then read address
    expect_ev(EV_DONE, 1'b0, 16'h0, "R2 write done");
    do_op(3'd3, 16'h4000, 1, "R2 write latency", 1'b0, 16'h0);
    expect_ev(EV_DONE, 1'b1, 16'h4000, "R2 read back");
    do_op(3'd2, 16'h0, 1, "R2 read latency", 1'b0, 16'h0);

    // R3: interrupt entry
    pc_cur = 16'h1234; a_cur = 16'h5555;
    expect_entry(16'h1234, 16'h5555, 16'h4000, 16'h0077, 1'b1, "R3 entry");
    do_op(3'd1, 16'h0077, 4, "R3 latency", 1'b0, 16'h0);
    chk(queueing == 1'b1, "R3 queueing on", int'(queueing), 1);

    // R7 / R8: queued software and hardware messages
    expect_ev(EV_DONE, 1'b0, 16'h0, "R7 queued done");
    do_op(3'd1, 16'h0088, 4, "R7 latency", 1'b0, 16'h0);
    hw_req = 1'b1; hw_msg = 16'h0099;
    @(negedge clk);
    hw_req = 1'b0;
    expect_ev(EV_DONE, 1'b0, 16'h0, "R8 same-cycle done");
    do_op(3'd1, 16'h00AA, 4, "R8 latency", 1'b1, 16'h00BB);

    // R5: return
    expect_ev(EV_POP, 1'b0, 16'h0, "R5 pop A");
    expect_ev(EV_AW, 1'b1, 16'h5555, "R5 A restored");
    expect_ev(EV_POP, 1'b0, 16'h0, "R5 pop PC");
    expect_ev(EV_PCW, 1'b1, 16'h1234, "R5 PC restored");
    expect_ev(EV_DONE, 1'b0, 16'h0, "R5 done");
    do_op(3'd4, 16'h0, 3, "R5 latency", 1'b0, 16'h0);
    chk(queueing == 1'b0, "R5 queueing off", int'(queueing), 0);

    // R9: boundary delivery in FIFO order
    pc_cur = 16'h2000; a_cur = 16'h0001;
    expect_entry(16'h2000, 16'h0001, 16'h4000, 16'h0088, 1'b0, "R9 first message");
    deliver(4, "R9 latency");
    chk(queueing == 1'b1, "R9 queueing on", int'(queueing), 1);
    deliver(0, "R9 no delivery while queueing");
    expect_ev(EV_DONE, 1'b0, 16'h0, "R6 done");
    do_op(3'd5, 16'h0, 2, "R6 latency", 1'b0, 16'h0);
    chk(queueing == 1'b0, "R6 queueing off", int'(queueing), 0);
    expect_entry(16'h2000, 16'h0001, 16'h4000, 16'h0099, 1'b0, "R8 hardware order");
    deliver(4, "R9 latency");
    expect_ev(EV_DONE, 1'b0, 16'h0, "R6 done");
    do_op(3'd5, 16'h0, 2, "R6 latency", 1'b0, 16'h0);
    expect_entry(16'h2000, 16'h0001, 16'h4000, 16'h00AA, 1'b0, "R8 software first");
    deliver(4, "R9 latency");
    expect_ev(EV_DONE, 1'b0, 16'h0, "R6 done");
    do_op(3'd5, 16'h0, 2, "R6 latency", 1'b0, 16'h0);
    expect_entry(16'h2000, 16'h0001, 16'h4000, 16'h00BB, 1'b0, "R8 hardware second");
    deliver(4, "R9 latency");
    expect_ev(EV_DONE, 1'b0, 16'h0, "R6 done");
    do_op(3'd5, 16'h0, 2, "R6 latency", 1'b0, 16'h0);
    deliver(0, "R9 empty FIFO");
    expect_ev(EV_DONE, 1'b0, 16'h0, "R6 done");
    do_op(3'd5, 16'h0005, 2, "R6 latency", 1'b0, 16'h0);
    chk(queueing == 1'b1, "R6 queueing on", int'(queueing), 1);

    // R11: ignored while busy and unknown kinds
    expect_ev(EV_DONE, 1'b0, 16'h0, "R11 single done");
    op_valid = 1'b1; op_kind = 3'd1; op_arg = 16'h0033;
    @(negedge clk);
    chk(op_busy == 1'b1, "R12 busy after accept", int'(op_busy), 1);
    op_kind = 3'd2;
    @(negedge clk);
    op_valid = 1'b0;
    while (op_busy) @(negedge clk);
    @(negedge clk);
    chk(op_busy == 1'b0, "R11 busy op ignored", int'(op_busy), 0);
    do_op(3'd0, 16'h0, 0, "R11 kind 0", 1'b0, 16'h0);
    do_op(3'd6, 16'h0, 0, "R11 kind 6", 1'b0, 16'h0);
    do_op(3'd7, 16'h0, 0, "R11 kind 7", 1'b0, 16'h0);

    // R10: fill (0x33 already stored), overflow, then drain
    for (int i = 1; i < DEPTH; i++) begin
      hw_req = 1'b1; hw_msg = 16'(16'h0100 + i);
      @(negedge clk);
    end
    hw_req = 1'b0;
    @(negedge clk);
    chk(ovf_fault == 1'b0, "R10 full without fault", int'(ovf_fault), 0);
    hw_req = 1'b1; hw_msg = 16'hBEEF;
    @(negedge clk);
    hw_req = 1'b0;
    chk(ovf_fault == 1'b1, "R10 overflow fault", int'(ovf_fault), 1);
    pc_cur = 16'h3000; a_cur = 16'h0002;
    for (int i = 0; i < DEPTH; i++) begin
      expect_ev(EV_DONE, 1'b0, 16'h0, "R6 done");
      do_op(3'd5, 16'h0, 2, "R6 latency", 1'b0, 16'h0);
      expect_entry(16'h3000, 16'h0002, 16'h4000,
                   (i == 0) ? 16'h0033 : 16'(16'h0100 + i), 1'b0, "R10 drain order");
      deliver(4, "R10 drain latency");
    end
    expect_ev(EV_DONE, 1'b0, 16'h0, "R6 done");
    do_op(3'd5, 16'h0, 2, "R6 latency", 1'b0, 16'h0);
    deliver(0, "R10 dropped message absent");
    chk(ovf_fault == 1'b1, "R10 fault sticky", int'(ovf_fault), 1);

    // R1: reset again
    do_reset();
    chk(ovf_fault == 1'b0, "R1 fault cleared", int'(ovf_fault), 0);
    chk(queueing == 1'b0, "R1 queueing cleared", int'(queueing), 0);
    expect_ev(EV_DONE, 1'b1, 16'h0000, "R1 address cleared");
    do_op(3'd2, 16'h0, 1, "R2 read latency", 1'b0, 16'h0);
    deliver(0, "R1 FIFO cleared");

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R3 all expected events seen", expq.size(), 0);
    finish_run();
  end

endmodule